// File: doc/BRIEF.md
# Serial Display Register Access Engine

This block is a bit-level serial master that reads and writes the internal registers of a small display controller. A host presents a command with an operation flag (write or read), an 8-bit register number, 16 bits of write data and a delay setting, using a valid/ready handshake. The engine then runs the serial pins: an active-low select, a clock that idles high, a data-out line and a data-in line.

Each register access is two framed transfers of 24 bits. Every frame begins with a start byte. The top six bits of the start byte are the fixed device ID 0x1D. Below them are a register-select bit and a direction bit. The first frame always names the register. The second frame either carries the value to write or shifts in the value being read. The select line goes high between the two frames. One programmable delay unit, counted in system clocks, sets every wait inside a frame, so it sets the serial speed.

When the second frame ends, the engine raises a one-cycle done pulse. For a read, the returned half-word is on the read-data port during that pulse.

Top module: `dispreg_spi_master`

## Requirements
- R1: After reset, and whenever no command is in progress, spi_cs_n, spi_sclk and spi_mosi are high, cmd_ready is high and rsp_done is low.
- R2: Every frame is 24 bits and is sent most significant bit first. spi_mosi takes the bit's value when spi_sclk falls and holds it until spi_sclk falls for the next bit. Between frames and when idle, spi_mosi is 1.
- R3: A write sends frame one as {0x74, 0x00, index} and then frame two as {0x76, wdata[15:0]}. Here 0x74 = {0x1D, select=0, dir=0} and 0x76 = {0x1D, select=1, dir=0}.
- R4: A read sends frame one as {0x74, 0x00, index} and then frame two as {0x77, 0x0000}. On the done pulse, rsp_rdata equals the low 16 bits of the 24 bits shifted in during frame two, first bit received as bit 23.
- R5: spi_miso is sampled on the last system clock of each clock-low phase, which is the edge where spi_sclk rises.
- R6: Let D be dly_cfg, with 0 treated as 1. A frame holds spi_cs_n low with spi_sclk high for D cycles. It then gives each bit D cycles with spi_sclk low and D cycles with spi_sclk high. spi_cs_n rises right after the last high phase.
- R7: Between the two frames, spi_cs_n stays high for exactly D cycles.
- R8: rsp_done is high for exactly one cycle, one cycle after spi_cs_n rises at the end of frame two. cmd_ready stays low from acceptance until the cycle after that pulse.
- R9: cmd_valid and the command fields are ignored while a transaction is in progress. dly_cfg is captured when the command is accepted, and later changes do not affect that transaction.
- R10: spi_sclk is low only while spi_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_index | input | 8 | Register number |
| cmd_wdata | input | 16 | Value for a write |
| dly_cfg | input | DLY_W | Delay unit in system clocks (0 acts as 1) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Half-word read back, valid with rsp_done |
| spi_cs_n | output | 1 | Active-low select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the display |
| spi_miso | input | 1 | Serial data from the display |

## Verification
The assertions assume that spi_miso comes from a device that changes it only after spi_sclk falls. They also assume that rst is held for at least one clock before commands are offered. The bench meets both conditions with a slave model that is driven by the pins' own edges, and it changes all host inputs on the falling system clock edge. Commands and dly_cfg changes are offered while the engine is busy, to show they are ignored. The bench also uses a zero delay, so the minimum-delay substitution is checked against the same pin timeline.

// File: rtl/dsra_pkg.sv
package dsra_pkg;

    localparam int FRAME_W = 24;
    localparam int IDX_W   = 8;
    localparam int HW_W    = 16;
    localparam int DLY_W   = 16;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [5:0] DEV_ID = 6'h1D;

    typedef enum logic { OP_WRITE = 1'b0, OP_READ = 1'b1 } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_GAP, ST_REL, ST_DONE
    } state_e;

    typedef struct packed {
        op_e               op;
        logic [IDX_W-1:0]  idx;
        logic [HW_W-1:0]   wdata;
    } cmd_t;

    // Start byte: device ID over register-select and direction bits.
    function automatic logic [7:0] start_byte(logic data_sel, logic rd);
        return {DEV_ID, data_sel, rd};
    endfunction

    // First frame names the register; second frame moves the value.
    function automatic logic [FRAME_W-1:0] frame_for(cmd_t c, logic second);
        if (!second)
            return {start_byte(1'b0, 1'b0), 8'h00, c.idx};
        else if (c.op == OP_READ)
            return {start_byte(1'b1, 1'b1), {HW_W{1'b0}}};
        else
            return {start_byte(1'b1, 1'b0), c.wdata};
    endfunction

endpackage

// File: rtl/dsra_delay.sv
module dsra_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign expire = en && (cnt == limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en || expire)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/dsra_shifter.sv
module dsra_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         sdi,
    output logic         msb,
    output logic [W-1:0] rx
);
    logic [W-1:0] tx;

    assign msb = tx[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '1;
            rx <= '0;
        end else if (load) begin
            tx <= load_val;
            rx <= '0;
        end else begin
            if (shift)  tx <= {tx[W-2:0], 1'b1};
            if (sample) rx <= {rx[W-2:0], sdi};
        end
    end
endmodule

// File: rtl/dsra_seq.sv
module dsra_seq
    import dsra_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  cmd_t               cmd_in,
    input  logic [DW-1:0]      dly_in,
    input  logic               expire,
    input  logic               tx_msb,
    output logic               ready,
    output logic               done,
    output logic               rel,
    output logic               cnt_en,
    output logic [DW-1:0]      dly_q,
    output logic               load,
    output logic [FRAME_W-1:0] load_val,
    output logic               shift,
    output logic               sample,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi
);
    state_e           st;
    cmd_t             cmd_q;
    logic             second;
    logic [BIT_W-1:0] bit_q;
    logic             accept;

    assign ready  = (st == ST_IDLE);
    assign accept = ready && cmd_valid;
    assign done   = (st == ST_DONE);
    assign rel    = (st == ST_REL);
    assign cnt_en = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH) || (st == ST_GAP);
    assign sample = (st == ST_LOW) && expire;
    assign shift  = (st == ST_HIGH) && expire;
    assign load   = accept || ((st == ST_GAP) && expire);
    assign load_val = (st == ST_IDLE) ? frame_for(cmd_in, 1'b0) : frame_for(cmd_q, 1'b1);

    assign cs_n = !((st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH));
    assign sclk = (st != ST_LOW);
    assign mosi = ((st == ST_LOW) || (st == ST_HIGH)) ? tx_msb : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cmd_q  <= '0;
            second <= 1'b0;
            bit_q  <= '0;
            dly_q  <= DW'(1);
        end else begin
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    cmd_q  <= cmd_in;
                    dly_q  <= (dly_in == '0) ? DW'(1) : dly_in;
                    second <= 1'b0;
                    st     <= ST_SETUP;
                end
                ST_SETUP: if (expire) begin
                    bit_q <= BIT_W'(FRAME_W - 1);
                    st    <= ST_LOW;
                end
                ST_LOW: if (expire) st <= ST_HIGH;
                ST_HIGH: if (expire) begin
                    if (bit_q == '0)
                        st <= second ? ST_REL : ST_GAP;
                    else begin
                        bit_q <= bit_q - BIT_W'(1);
                        st    <= ST_LOW;
                    end
                end
                ST_GAP: if (expire) begin
                    second <= 1'b1;
                    st     <= ST_SETUP;
                end
                ST_REL:  st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dispreg_spi_master.sv
module dispreg_spi_master
    import dsra_pkg::*;
#(
    parameter int DLY_W = dsra_pkg::DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_read,
    input  logic [7:0]       cmd_index,
    input  logic [15:0]      cmd_wdata,
    input  logic [DLY_W-1:0] dly_cfg,
    output logic             rsp_done,
    output logic [15:0]      rsp_rdata,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    cmd_t               cmd_in;
    logic               expire, rel, cnt_en, load, shift, sample, tx_msb;
    logic [DLY_W-1:0]   dly_q;
    logic [FRAME_W-1:0] load_val, rx;
    logic [HW_W-1:0]    rd_q;

    assign cmd_in = '{op: op_e'(cmd_read), idx: cmd_index, wdata: cmd_wdata};

    dsra_seq #(.DW(DLY_W)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_in(cmd_in),
        .dly_in(dly_cfg), .expire(expire), .tx_msb(tx_msb),
        .ready(cmd_ready), .done(rsp_done), .rel(rel), .cnt_en(cnt_en),
        .dly_q(dly_q), .load(load), .load_val(load_val), .shift(shift),
        .sample(sample), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    dsra_delay #(.W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .en(cnt_en), .limit(dly_q), .expire(expire)
    );

    dsra_shifter #(.W(FRAME_W)) u_shf (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .shift(shift), .sample(sample), .sdi(spi_miso),
        .msb(tx_msb), .rx(rx)
    );

    always_ff @(posedge clk) begin
        if (rst)      rd_q <= '0;
        else if (rel) rd_q <= rx[HW_W-1:0];
    end

    assign rsp_rdata = rd_q;
endmodule

// File: rtl/dsra_chk.sv
module dsra_chk (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic rsp_done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (spi_cs_n && spi_sclk && spi_mosi && !rsp_done));

    // R10
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_sclk |-> !spi_cs_n);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R8
    done_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (spi_cs_n && $past(spi_cs_n) && !$past(spi_cs_n, 2)));

    // R8
    ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> cmd_ready);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sclk && !$fell(spi_cs_n) && $past(!spi_cs_n) && $past(spi_sclk) == 1'b0)
        |-> $stable(spi_mosi));
endmodule

bind dispreg_spi_master dsra_chk u_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .rsp_done(rsp_done),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/dispreg_spi_master_tb.sv
module dispreg_spi_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [7:0]  cmd_index = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] dly_cfg = 16'd1;
    logic        spi_miso = 1'b0;
    logic        cmd_ready, rsp_done, spi_cs_n, spi_sclk, spi_mosi;
    logic [15:0] rsp_rdata;

    always #5 clk = ~clk;

    dispreg_spi_master u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_read(cmd_read), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
        .dly_cfg(dly_cfg), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Slave: presents response bits MSB first, changing after each falling sclk.
    logic [23:0] resp = 24'h0;
    int sl_cnt = 0;
    always @(negedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) sl_cnt <= 0;
        else begin
            spi_miso <= resp[23 - sl_cnt];
            sl_cnt   <= sl_cnt + 1;
        end
    end

    // Behavioural reference: a timeline index k counted from acceptance.
    bit          busy = 0;
    int          k = 0, D = 1;
    bit          m_read = 0;
    logic [23:0] f0, f1, m_resp;
    always @(posedge clk) begin
        if (rst) busy = 0;
        else if (!busy) begin
            if (cmd_valid) begin
                busy   = 1; k = 0;
                D      = (dly_cfg == 0) ? 1 : int'(dly_cfg);
                m_read = cmd_read;
                f0     = {8'h74, 8'h00, cmd_index};
                f1     = cmd_read ? {8'h77, 16'h0000} : {8'h76, cmd_wdata};
                m_resp = resp;
            end
        end else if (k == 99*D + 1) busy = 0;
        else k++;
    end

    task automatic frame_exp(input int j, input logic [23:0] f,
                             output logic cs, output logic sc, output logic mo);
        int m;
        if (j < D) begin cs = 0; sc = 1; mo = 1; end
        else begin
            m  = j - D;
            cs = 0;
            sc = ((m % (2*D)) < D) ? 1'b0 : 1'b1;
            mo = f[23 - m/(2*D)];
        end
    endtask

    always @(negedge clk) begin
        logic e_cs, e_sc, e_mo, e_done, e_ready;
        if (!rst && !finished) begin
            e_cs = 1; e_sc = 1; e_mo = 1; e_done = 0; e_ready = !busy;
            if (busy) begin
                if (k < 49*D)                   frame_exp(k, f0, e_cs, e_sc, e_mo);
                else if (k >= 50*D && k < 99*D) frame_exp(k - 50*D, f1, e_cs, e_sc, e_mo);
                else if (k == 99*D + 1)         e_done = 1;
            end
            checks++;
            if (spi_cs_n !== e_cs || spi_sclk !== e_sc) begin
                fails++;
                $display("FAIL R6/R7/R10 t=%0t k=%0d cs_n,sclk=%b%b expected %b%b",
                         $time, k, spi_cs_n, spi_sclk, e_cs, e_sc);
            end else if (spi_mosi !== e_mo) begin
                fails++;
                $display("FAIL R2/R3/R4 t=%0t k=%0d mosi=%b expected %b", $time, k, spi_mosi, e_mo);
            end else if (rsp_done !== e_done || cmd_ready !== e_ready) begin
                fails++;
                $display("FAIL R8/R9 t=%0t k=%0d done,ready=%b%b expected %b%b",
                         $time, k, rsp_done, cmd_ready, e_done, e_ready);
            end
            if (e_done && m_read) begin
                checks++;
                if (rsp_rdata !== m_resp[15:0]) begin
                    fails++;
                    $display("FAIL R4/R5 rdata=%h expected %h", rsp_rdata, m_resp[15:0]);
                end
            end
        end
    end

    task automatic run_cmd(input logic rd, input logic [7:0] idx, input logic [15:0] wd,
                           input logic [15:0] dl, input logic [23:0] rsp, input bit disturb);
        @(negedge clk);
        resp = rsp; cmd_read = rd; cmd_index = idx; cmd_wdata = wd; dly_cfg = dl;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        if (disturb) begin
            // R9: other commands and a new delay offered while busy
            repeat (7) @(negedge clk);
            cmd_valid = 1; cmd_read = ~rd; cmd_index = ~idx; cmd_wdata = ~wd; dly_cfg = 16'd9;
            repeat (40) @(negedge clk);
            cmd_valid = 0;
        end
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({spi_cs_n, spi_sclk, spi_mosi, cmd_ready, rsp_done} !== 5'b11110) begin
            fails++;
            $display("FAIL R1 pins=%b expected 11110",
                     {spi_cs_n, spi_sclk, spi_mosi, cmd_ready, rsp_done});
        end
        rst = 0;
        repeat (2) @(negedge clk);
        run_cmd(1'b0, 8'h07, 16'h0015, 16'd1, 24'h000000, 0);   // R3 write
        run_cmd(1'b1, 8'h00, 16'h0000, 16'd2, 24'hA50139, 0);   // R4 R5 read
        run_cmd(1'b0, 8'h13, 16'hA55A, 16'd3, 24'h000000, 1);   // R9
        run_cmd(1'b1, 8'hFF, 16'h0000, 16'd0, 24'h5AC3F0, 0);   // R6 zero delay
        run_cmd(1'b1, 8'h80, 16'h0000, 16'd1, 24'hFFFFFF, 1);   // R4 R9 read
        run_cmd(1'b0, 8'hFF, 16'hFFFF, 16'd2, 24'h000000, 0);   // R2 R7
        run_cmd(1'b0, 8'h00, 16'h0001, 16'd1, 24'h000000, 0);   // R3
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule